// File: doc/BRIEF.md
# Narrow-Port Descriptor Memory Bridge

This block gives an 8-bit or 16-bit processor port access to a small memory of 32-bit channel descriptors. The port is too narrow to carry a whole descriptor, so writes arrive in pieces. Each piece below the top lane is parked in a holding register. The write that carries the top lane then commits the full 32-bit word to the addressed entry in a single cycle. A mode input chooses whether an access is a byte or a halfword. The low two address bits choose the lane.

Every entry has two regions. The static region is one 32-bit word: a 24-bit base address in bits [23:0] and an 8-bit depth in bits [31:24]. The scratchpad region holds a writable 8-bit depth in bits [31:24] and a read-only 24-bit current offset in bits [23:0]. A commit to an entry always returns that entry's current offset to zero. An advance port stands in for the consumer that walks through a channel. It steps the offset of one entry and wraps the offset at the scratchpad depth.

Reads use two separate commands, one for the static word and one for the scratchpad word. Both return the lane picked by the same address decoding that writes use. The result appears on a registered output one cycle later.

Top module: `desc_lane_bridge`

## Requirements
- R1: After reset every static word, scratchpad depth, current offset and holding register is zero, and `rd_data` is 0.
- R2: `cmd` encoding: 0 idle, 1 write, 2 read static, 3 read scratchpad. A byte-mode write (`wide_mode`=0) with `lane_addr` 0, 1 or 2 stores `wr_data[7:0]` in byte holding register 0, 1 or 2 and leaves memory unchanged.
- R3: A byte-mode write with `lane_addr`=3 commits {`wr_data[7:0]`, hold2, hold1, hold0} (bits 31..0) to entry `entry_idx` in the same clock edge.
- R4: A word-mode write (`wide_mode`=1) with `lane_addr[1]`=0 stores `wr_data[15:0]` in the halfword holding register, with byte 1 on bits [15:8]. It does not touch memory.
- R5: A word-mode write with `lane_addr[1]`=1 commits {`wr_data[15:0]`, held halfword} to entry `entry_idx`.
- R6: `region_sel`=0 makes a commit replace the whole static word. `region_sel`=1 makes a commit set only the scratchpad depth, from committed bits [31:24]; committed bits [23:0] are discarded.
- R7: Every commit, to either region, sets the addressed entry's current offset to 0.
- R8: `adv_en` steps the offset of entry `adv_idx` by one. The offset returns to 0 when the stepped value would reach the scratchpad depth. A depth of 0 or 1 keeps the offset at 0.
- R9: When a commit and an advance hit the same entry in one cycle, the offset becomes 0. An advance to a different entry still takes effect.
- R10: A read returns data on `rd_data` one cycle after the command. In byte mode the value is {8'h00, byte `lane_addr`}. In word mode it is bits [31:16] when `lane_addr[1]`=1 and bits [15:0] otherwise. Scratchpad reads return {depth, offset}. Between reads `rd_data` holds its value.
- R11: The holding registers are shared by all entries and keep their contents after a commit, so a later top-lane write to another entry reuses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0 = byte access, 1 = halfword access |
| lane_addr | input | 2 | Low address bits selecting the lane |
| entry_idx | input | 4 | Descriptor entry addressed by the command |
| cmd | input | 2 | 0 idle, 1 write, 2 read static, 3 read scratchpad |
| region_sel | input | 1 | Commit target: 0 static, 1 scratchpad |
| wr_data | input | 16 | Write data; byte mode uses bits [7:0] |
| adv_en | input | 1 | Step the current offset of entry `adv_idx` |
| adv_idx | input | 4 | Entry whose offset is stepped |
| rd_data | output | 16 | Registered read result |

## Verification
The hardest case to reach is a commit and an advance that land on the same entry in the same cycle, after that entry's offset has already moved away from zero. The stimulus first programs a non-trivial scratchpad depth. It then advances the entry a few times and reads the offset back to show it is non-zero. Only then does it issue the top-lane write with `adv_en` raised for the same index, and a scratchpad read follows. A long pseudo-random phase afterwards mixes modes, lanes, regions and advances. A behavioural model tracks every entry, and the bench compares against it each cycle, so overlaps on different entries and wrap points at small depths are also covered.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int DEPTH_W = 8;
    localparam int OFFS_W  = WORD_W - DEPTH_W;
    localparam int HOLD_BYTES = (WORD_W / BYTE_W) - 1;

    typedef enum logic [1:0] {
        CMD_IDLE       = 2'd0,
        CMD_WRITE      = 2'd1,
        CMD_RD_STATIC  = 2'd2,
        CMD_RD_SCRATCH = 2'd3
    } dlb_cmd_e;

    typedef struct packed {
        logic [WORD_W-1:0]  stat;
        logic [DEPTH_W-1:0] sdepth;
        logic [OFFS_W-1:0]  soff;
    } dlb_entry_t;

    typedef struct packed {
        logic [HOLD_BYTES-1:0][BYTE_W-1:0] hb;
        logic [HALF_W-1:0]                 hw;
    } dlb_hold_t;

endpackage

// File: rtl/dlb_lane_hold.sv
module dlb_lane_hold
    import dlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wide_mode,
    input  logic [1:0]        lane_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              commit_en,
    output logic [WORD_W-1:0] commit_word
);

    localparam logic [1:0] TOP_LANE = 2'(HOLD_BYTES);

    dlb_hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        commit_en   = 1'b0;
        commit_word = {wr_data[BYTE_W-1:0], hold_q.hb[2], hold_q.hb[1], hold_q.hb[0]};
        if (wide_mode) begin
            commit_word = {wr_data, hold_q.hw};
            if (wr_en) begin
                if (lane_addr[1]) begin
                    commit_en = 1'b1;
                end else begin
                    hold_d.hw = wr_data;
                end
            end
        end else if (wr_en) begin
            if (lane_addr == TOP_LANE) begin
                commit_en = 1'b1;
            end else begin
                for (int i = 0; i < HOLD_BYTES; i++) begin
                    if (lane_addr == 2'(i)) begin
                        hold_d.hb[i] = wr_data[BYTE_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/dlb_desc_store.sv
module dlb_desc_store
    import dlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic              commit_region,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic [WORD_W-1:0] commit_word,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  adv_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_static,
    output logic [WORD_W-1:0] rd_scratch
);

    logic [ENTRIES-1:0][WORD_W-1:0] stat_arr;
    logic [ENTRIES-1:0][WORD_W-1:0] scr_arr;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        dlb_entry_t        ent_d, ent_q;
        logic              hit_commit;
        logic              hit_adv;
        logic [OFFS_W-1:0] off_inc;

        always_comb begin
            ent_d      = ent_q;
            hit_commit = commit_en && (commit_idx == IDX_W'(e));
            hit_adv    = adv_en && (adv_idx == IDX_W'(e));
            off_inc    = ent_q.soff + OFFS_W'(1);
            if (hit_adv) begin
                if (off_inc >= OFFS_W'(ent_q.sdepth)) begin
                    ent_d.soff = '0;
                end else begin
                    ent_d.soff = off_inc;
                end
            end
            if (hit_commit) begin
                ent_d.soff = '0;
                if (commit_region) begin
                    ent_d.sdepth = commit_word[WORD_W-1:OFFS_W];
                end else begin
                    ent_d.stat = commit_word;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign stat_arr[e] = ent_q.stat;
        assign scr_arr[e]  = {ent_q.sdepth, ent_q.soff};
    end

    assign rd_static  = stat_arr[rd_idx];
    assign rd_scratch = scr_arr[rd_idx];

endmodule

// File: rtl/dlb_read_lane.sv
module dlb_read_lane
    import dlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_scratch_sel,
    input  logic              wide_mode,
    input  logic [1:0]        lane_addr,
    input  logic [WORD_W-1:0] static_word,
    input  logic [WORD_W-1:0] scratch_word,
    output logic [HALF_W-1:0] rd_data
);

    typedef struct packed {
        logic [HALF_W-1:0] data;
    } rd_state_t;

    rd_state_t         rd_d, rd_q;
    logic [WORD_W-1:0] src_word;

    always_comb begin
        rd_d     = rd_q;
        src_word = rd_scratch_sel ? scratch_word : static_word;
        if (rd_en) begin
            if (wide_mode) begin
                rd_d.data = lane_addr[1] ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
            end else begin
                rd_d.data = {{(HALF_W-BYTE_W){1'b0}}, src_word[{lane_addr, 3'b000} +: BYTE_W]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

endmodule

// File: rtl/desc_lane_bridge.sv
module desc_lane_bridge
    import dlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [1:0]        lane_addr,
    input  logic [IDX_W-1:0]  entry_idx,
    input  logic [1:0]        cmd,
    input  logic              region_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  adv_idx,
    output logic [HALF_W-1:0] rd_data
);

    dlb_cmd_e          cmd_e;
    logic              wr_en;
    logic              rd_en;
    logic              commit_en;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] static_word;
    logic [WORD_W-1:0] scratch_word;

    assign cmd_e = dlb_cmd_e'(cmd);
    assign wr_en = (cmd_e == CMD_WRITE);
    assign rd_en = (cmd_e == CMD_RD_STATIC) || (cmd_e == CMD_RD_SCRATCH);

    dlb_lane_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wide_mode   (wide_mode),
        .lane_addr   (lane_addr),
        .wr_data     (wr_data),
        .commit_en   (commit_en),
        .commit_word (commit_word)
    );

    dlb_desc_store #(.ENTRIES(ENTRIES)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en     (commit_en),
        .commit_region (region_sel),
        .commit_idx    (entry_idx),
        .commit_word   (commit_word),
        .adv_en        (adv_en),
        .adv_idx       (adv_idx),
        .rd_idx        (entry_idx),
        .rd_static     (static_word),
        .rd_scratch    (scratch_word)
    );

    dlb_read_lane u_read (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_en          (rd_en),
        .rd_scratch_sel (cmd_e == CMD_RD_SCRATCH),
        .wide_mode      (wide_mode),
        .lane_addr      (lane_addr),
        .static_word    (static_word),
        .scratch_word   (scratch_word),
        .rd_data        (rd_data)
    );

endmodule

// File: rtl/dlb_checker.sv
module dlb_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd,
    input logic             wide_mode,
    input logic [1:0]       lane_addr,
    input logic [IDX_W-1:0] entry_idx,
    input logic             adv_en,
    input logic [IDX_W-1:0] adv_idx,
    input logic             commit_en,
    input logic [15:0]      rd_data
);

    a_r2_no_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'd1) |-> !commit_en);

    a_r2_low_byte_holds_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 && !wide_mode && lane_addr != 2'd3) |-> !commit_en);

    a_r3_top_byte_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 && !wide_mode && lane_addr == 2'd3) |-> commit_en);

    a_r4_low_half_holds_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 && wide_mode && !lane_addr[1]) |-> !commit_en);

    a_r5_high_half_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 && wide_mode && lane_addr[1]) |-> commit_en);

    a_r7_commit_zeroes_offset: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en ##1 (cmd == 2'd3 && wide_mode && !lane_addr[1]
                       && entry_idx == $past(entry_idx)
                       && !(adv_en && adv_idx == entry_idx))
        |=> (rd_data == 16'h0000));

    a_r10_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[1] && !wide_mode) |=> (rd_data[15:8] == 8'h00));

    a_r10_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd[1]) |=> $stable(rd_data));

endmodule

bind desc_lane_bridge dlb_checker #(.IDX_W(IDX_W)) u_dlb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .wide_mode (wide_mode),
    .lane_addr (lane_addr),
    .entry_idx (entry_idx),
    .adv_en    (adv_en),
    .adv_idx   (adv_idx),
    .commit_en (commit_en),
    .rd_data   (rd_data)
);

// File: tb/sim_desc_lane_bridge.sv
`timescale 1ns/1ps
module sim_desc_lane_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [1:0]  lane_addr = '0;
    logic [3:0]  entry_idx = '0;
    logic [1:0]  cmd = '0;
    logic        region_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        adv_en = 1'b0;
    logic [3:0]  adv_idx = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat [16];
    int          m_depth [16];
    int          m_off [16];
    logic [7:0]  m_hb [3];
    logic [15:0] m_hw;
    logic [15:0] exp_rd;

    always #4 clk = ~clk;

    desc_lane_bridge u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .lane_addr  (lane_addr),
        .entry_idx  (entry_idx),
        .cmd        (cmd),
        .region_sel (region_sel),
        .wr_data    (wr_data),
        .adv_en     (adv_en),
        .adv_idx    (adv_idx),
        .rd_data    (rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update(input logic [1:0] c, input logic w, input logic [1:0] ln,
                                input int idx, input logic rg, input logic [15:0] d,
                                input logic ae, input int ai);
        logic [31:0] word;
        logic [31:0] cw;
        int          new_off [16];
        bit          do_commit;
        int          n;
        if (c[1]) begin
            if (c == 2'd2) word = m_stat[idx];
            else           word = {m_depth[idx][7:0], m_off[idx][23:0]};
            if (w) exp_rd = ln[1] ? word[31:16] : word[15:0];
            else   exp_rd = {8'h00, 8'((word >> (ln * 8)) & 32'hFF)};
        end
        for (int k = 0; k < 16; k++) new_off[k] = m_off[k];
        if (ae) begin
            n = m_off[ai] + 1;
            if (n >= m_depth[ai]) n = 0;
            new_off[ai] = n;
        end
        do_commit = 1'b0;
        cw = '0;
        if (c == 2'd1) begin
            if (w) begin
                if (ln[1]) begin do_commit = 1'b1; cw = {d, m_hw}; end
                else m_hw = d;
            end else begin
                if (ln == 2'd3) begin do_commit = 1'b1; cw = {d[7:0], m_hb[2], m_hb[1], m_hb[0]}; end
                else m_hb[ln] = d[7:0];
            end
        end
        if (do_commit) begin
            if (rg) m_depth[idx] = int'(cw[31:24]);
            else    m_stat[idx] = cw;
            new_off[idx] = 0;
        end
        for (int k = 0; k < 16; k++) m_off[k] = new_off[k];
    endtask

    task automatic step(input logic [1:0] c, input logic w, input logic [1:0] ln,
                        input int idx, input logic rg, input logic [15:0] d,
                        input logic ae, input int ai, input string tag);
        cmd = c; wide_mode = w; lane_addr = ln; entry_idx = 4'(idx);
        region_sel = rg; wr_data = d; adv_en = ae; adv_idx = 4'(ai);
        @(posedge clk);
        model_update(c, w, ln, idx, rg, d, ae, ai);
        @(negedge clk);
        check(rd_data, exp_rd, tag);
        cmd = 2'd0; adv_en = 1'b0;
    endtask

    task automatic wbyte(input int idx, input logic [1:0] ln, input logic rg, input logic [7:0] d, input string tag);
        step(2'd1, 1'b0, ln, idx, rg, {8'hA5, d}, 1'b0, 0, tag);
    endtask

    task automatic wword(input int idx, input logic [1:0] ln, input logic rg, input logic [15:0] d, input string tag);
        step(2'd1, 1'b1, ln, idx, rg, d, 1'b0, 0, tag);
    endtask

    task automatic rd(input logic [1:0] c, input logic w, input logic [1:0] ln, input int idx,
                      input logic [15:0] lit, input string tag);
        step(c, w, ln, idx, 1'b0, 16'h0, 1'b0, 0, tag);
        check(rd_data, lit, tag);
    endtask

    task automatic adv(input int ai, input string tag);
        step(2'd0, 1'b0, 2'd0, 0, 1'b0, 16'h0, 1'b1, ai, tag);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin m_stat[k] = '0; m_depth[k] = 0; m_off[k] = 0; end
        for (int k = 0; k < 3; k++) m_hb[k] = '0;
        m_hw = '0;
        exp_rd = '0;
        repeat (3) @(negedge clk);
        check(rd_data, 16'h0000, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd2, 1'b1, 2'd0, 0, 16'h0000, "R1 static cleared");
        rd(2'd3, 1'b1, 2'd2, 15, 16'h0000, "R1 scratch cleared");

        wbyte(3, 2'd0, 1'b0, 8'h11, "R2");
        wbyte(3, 2'd1, 1'b0, 8'h22, "R2");
        wbyte(3, 2'd2, 1'b0, 8'h33, "R2");
        rd(2'd2, 1'b1, 2'd0, 3, 16'h0000, "R2 memory untouched");
        wbyte(3, 2'd3, 1'b0, 8'h44, "R3");
        rd(2'd2, 1'b0, 2'd0, 3, 16'h0011, "R3 byte0");
        rd(2'd2, 1'b0, 2'd1, 3, 16'h0022, "R10 byte1");
        rd(2'd2, 1'b0, 2'd2, 3, 16'h0033, "R10 byte2");
        rd(2'd2, 1'b0, 2'd3, 3, 16'h0044, "R3 byte3");
        rd(2'd2, 1'b1, 2'd1, 3, 16'h2211, "R10 low half");
        rd(2'd2, 1'b1, 2'd3, 3, 16'h4433, "R10 high half");
        repeat (3) step(2'd0, 1'b0, 2'd0, 0, 1'b0, 16'hFFFF, 1'b0, 0, "R10 hold");
        check(rd_data, 16'h4433, "R10 held value");

        wbyte(4, 2'd3, 1'b0, 8'h55, "R11");
        rd(2'd2, 1'b1, 2'd2, 4, 16'h5533, "R11 reused holds");

        wword(7, 2'd0, 1'b0, 16'hBBAA, "R4");
        rd(2'd2, 1'b1, 2'd0, 7, 16'h0000, "R4 memory untouched");
        wword(7, 2'd2, 1'b0, 16'hDDCC, "R5");
        rd(2'd2, 1'b0, 2'd1, 7, 16'h00BB, "R4 byte1 from high bits");
        rd(2'd2, 1'b1, 2'd2, 7, 16'hDDCC, "R5 high half");

        wword(7, 2'd0, 1'b1, 16'h1234, "R6");
        wword(7, 2'd2, 1'b1, 16'h05FF, "R6");
        rd(2'd3, 1'b1, 2'd2, 7, 16'h0500, "R6 scratch depth");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0000, "R6 offset not written");
        rd(2'd2, 1'b1, 2'd2, 7, 16'hDDCC, "R6 static kept");

        repeat (4) adv(7, "R8");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0004, "R8 offset 4");
        adv(7, "R8");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0000, "R8 wrap");
        repeat (3) adv(7, "R8");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0003, "R8 offset 3");
        wword(7, 2'd2, 1'b0, 16'hDDCC, "R7");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0000, "R7 static commit clears offset");
        rd(2'd3, 1'b1, 2'd2, 7, 16'h0500, "R7 depth kept");

        repeat (2) adv(7, "R9");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0002, "R9 offset 2");
        step(2'd1, 1'b1, 2'd2, 7, 1'b0, 16'hDDCC, 1'b1, 7, "R9");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0000, "R9 commit wins");
        step(2'd1, 1'b1, 2'd2, 4, 1'b0, 16'h7777, 1'b1, 7, "R9");
        rd(2'd3, 1'b1, 2'd0, 7, 16'h0001, "R9 other entry advances");

        adv(0, "R8");
        rd(2'd3, 1'b1, 2'd0, 0, 16'h0000, "R8 depth zero");
        wword(1, 2'd2, 1'b1, 16'h0100, "R8");
        adv(1, "R8");
        adv(1, "R8");
        rd(2'd3, 1'b1, 2'd0, 1, 16'h0000, "R8 depth one");

        for (int i = 0; i < 600; i++) begin
            logic [1:0] rc;
            rc = 2'($urandom % 4);
            step(rc, 1'($urandom), 2'($urandom), int'($urandom % 16), 1'($urandom),
                 16'($urandom), 1'($urandom), int'($urandom % 16), "R10 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule